// File: doc/BRIEF.md
# Receive Decimation Chain Configuration Controller

This block turns a requested receive decimation factor into the settings of a three-stage decimating filter chain: a variable-rate CIC stage, then a light halfband stage, then a heavy halfband stage. Each halfband stage decimates by two when enabled and the CIC takes whatever ratio is left. A factor is presented on a data input and taken only when a load strobe is high; a factor outside the legal set is refused, an error flag is raised and the running configuration stays as it was.

Alongside the configuration, the block paces the chain: from the input sample-valid it produces one output strobe per stage, each stage strobe firing once per that stage's ratio of strobes from the stage before it. A bypassed stage forwards its input strobe unchanged. Accepting a new factor clears every stage's sample count, so no stage ever emits an output built from a partial period. The filter arithmetic itself lives elsewhere and consumes these flags and strobes.

Top module: `decim_chain_ctrl`

## Requirements
- R1: A factor F on `factor_in` is legal when 1 <= F <= 128, or 130 <= F <= 256 with F even, or 260 <= F <= 512 with F a multiple of 4. A load with an illegal F sets `cfg_err` one cycle later; a load with a legal F clears it one cycle later; without a load `cfg_err` holds.
- R2: A load with an illegal F leaves `cic_rate`, `cic_bypass`, `hbl_en` and `hbh_en` unchanged and does not clear the stage counts.
- R3: A legal F that is a multiple of 4 drives `hbl_en`=1 and `hbh_en`=1 from the cycle after the load.
- R4: A legal F that is even but not a multiple of 4 drives `hbl_en`=0 and `hbh_en`=1.
- R5: A legal odd F drives `hbl_en`=0 and `hbh_en`=0.
- R6: `cic_rate` equals F divided by 2 for each enabled halfband; `cic_bypass`=1 exactly when that value is 1.
- R7: After reset the configuration is that of F=1 (`cic_rate`=1, `cic_bypass`=1, both halfbands off), `cfg_err`=0 and all strobes low.
- R8: `cic_stb` pulses for one cycle, one cycle after every `cic_rate`-th `in_valid` pulse counted since the last accepted load (every pulse when the CIC is bypassed).
- R9: `hbl_stb` pulses on every second `cic_stb` when `hbl_en`=1 and equals `cic_stb` otherwise; `hbh_stb` relates to `hbl_stb` in the same way through `hbh_en`. Strobes of all stages for one input sample appear in the same cycle.
- R10: A legal load clears all stage counts; an `in_valid` in the same cycle as that load is not counted, and no strobe fires in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| factor_in | input | 10 | Requested decimation factor |
| load | input | 1 | Take `factor_in` this cycle |
| in_valid | input | 1 | One input sample is present |
| cic_rate | output | 8 | CIC decimation ratio (1 when bypassed) |
| cic_bypass | output | 1 | CIC stage bypassed |
| hbl_en | output | 1 | Light halfband enabled |
| hbh_en | output | 1 | Heavy halfband enabled |
| cic_stb | output | 1 | CIC stage output strobe |
| hbl_stb | output | 1 | Light halfband output strobe |
| hbh_stb | output | 1 | Heavy halfband output strobe |
| cfg_err | output | 1 | Last load carried an illegal factor |

## Verification
Every result is due one cycle after the edge that samples its cause: configuration and `cfg_err` one cycle after the load, and all three stage strobes one cycle after the `in_valid` that completes their periods. The bench drives inputs on the falling edge, advances a behavioural model of counts and settings on the rising edge, and compares every output on the next falling edge, so each comparison lands exactly in the cycle the result is due. Loads are issued with `in_valid` high to exercise the discarded sample, and illegal factors are slipped between legal ones so that held settings and undisturbed counts are seen at the strobes.

// File: rtl/decim_cfg_pkg.sv
package decim_cfg_pkg;

  // Fixed ratio of each halfband stage when enabled.
  localparam int HB_RATIO = 2;

  // Position of each stage in the chain, CIC first.
  typedef enum logic [1:0] {
    STG_CIC = 2'd0,
    STG_HBL = 2'd1,
    STG_HBH = 2'd2
  } stage_e;

  localparam int NUM_STAGES = 3;

endpackage

// File: rtl/factor_split.sv
module factor_split #(
  parameter int CIC_MAX  = 128,
  parameter int FACTOR_W = 10,
  parameter int RATE_W   = 8
) (
  input  logic [FACTOR_W-1:0] factor,
  output logic                legal,
  output logic                hbl_on,
  output logic                hbh_on,
  output logic                cic_byp,
  output logic [RATE_W-1:0]   cic_rate
);

  localparam int TIER2 = CIC_MAX * 2;
  localparam int TIER3 = CIC_MAX * 4;

  logic in_t1, in_t2, in_t3;
  logic [1:0] shift;
  logic [FACTOR_W-1:0] rest;

  always_comb begin
    in_t1 = (factor >= FACTOR_W'(1)) && (factor <= FACTOR_W'(CIC_MAX));
    in_t2 = (factor > FACTOR_W'(CIC_MAX)) && (factor <= FACTOR_W'(TIER2)) && !factor[0];
    in_t3 = (factor > FACTOR_W'(TIER2)) && (factor <= FACTOR_W'(TIER3)) && (factor[1:0] == 2'b00);
    legal = in_t1 || in_t2 || in_t3;

    hbl_on = (factor[1:0] == 2'b00);
    hbh_on = !factor[0];
    shift  = {1'b0, hbl_on} + {1'b0, hbh_on};
    rest   = factor >> shift;
    cic_rate = rest[RATE_W-1:0];
    cic_byp  = (rest == FACTOR_W'(1));
  end

endmodule

// File: rtl/stage_div.sv
module stage_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             bypass,
  input  logic [CNT_W-1:0] ratio,
  input  logic             in_fire,
  output logic             out_fire
);

  logic [CNT_W-1:0] cnt;
  logic             last;

  assign last     = (cnt == ratio - CNT_W'(1));
  assign out_fire = in_fire && (bypass || last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (in_fire && !bypass) begin
      cnt <= last ? '0 : cnt + CNT_W'(1);
    end
  end

  // R8: an active stage never holds a count at or beyond its ratio
  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
    !bypass |-> (cnt < ratio));

  // R9: a bypassed stage keeps no partial count
  assert_byp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    bypass |-> (cnt == '0));

endmodule

// File: rtl/decim_chain_ctrl.sv
module decim_chain_ctrl
  import decim_cfg_pkg::*;
#(
  parameter int CIC_MAX  = 128,
  parameter int FACTOR_W = 10,
  parameter int RATE_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FACTOR_W-1:0] factor_in,
  input  logic                load,
  input  logic                in_valid,
  output logic [RATE_W-1:0]   cic_rate,
  output logic                cic_bypass,
  output logic                hbl_en,
  output logic                hbh_en,
  output logic                cic_stb,
  output logic                hbl_stb,
  output logic                hbh_stb,
  output logic                cfg_err
);

  localparam int HB_W = $clog2(HB_RATIO) + 1;

  logic              d_legal, d_hbl, d_hbh, d_byp;
  logic [RATE_W-1:0] d_rate;
  logic              apply;
  logic [NUM_STAGES-1:0] fire;
  logic [NUM_STAGES-1:0] hb_en_vec;

  factor_split #(
    .CIC_MAX (CIC_MAX),
    .FACTOR_W(FACTOR_W),
    .RATE_W  (RATE_W)
  ) u_split (
    .factor  (factor_in),
    .legal   (d_legal),
    .hbl_on  (d_hbl),
    .hbh_on  (d_hbh),
    .cic_byp (d_byp),
    .cic_rate(d_rate)
  );

  assign apply = load && d_legal;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      cic_rate   <= RATE_W'(1);
      cic_bypass <= 1'b1;
      hbl_en     <= 1'b0;
      hbh_en     <= 1'b0;
      cfg_err    <= 1'b0;
    end else if (load) begin
      cfg_err <= !d_legal;
      if (d_legal) begin
        cic_rate   <= d_rate;
        cic_bypass <= d_byp;
        hbl_en     <= d_hbl;
        hbh_en     <= d_hbh;
      end
    end
  end

  // CIC stage pacing
  stage_div #(.CNT_W(RATE_W)) u_cic (
    .clk     (clk),
    .rst     (rst),
    .clr     (apply),
    .bypass  (cic_bypass),
    .ratio   (cic_rate),
    .in_fire (in_valid && !apply),
    .out_fire(fire[STG_CIC])
  );

  assign hb_en_vec = {hbh_en, hbl_en, 1'b0};

  // Halfband stage pacing, each fed by the stage before it
  for (genvar s = 1; s < NUM_STAGES; s++) begin : g_hb
    stage_div #(.CNT_W(HB_W)) u_hb (
      .clk     (clk),
      .rst     (rst),
      .clr     (apply),
      .bypass  (!hb_en_vec[s]),
      .ratio   (HB_W'(HB_RATIO)),
      .in_fire (fire[s-1]),
      .out_fire(fire[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cic_stb <= 1'b0;
      hbl_stb <= 1'b0;
      hbh_stb <= 1'b0;
    end else begin
      cic_stb <= fire[STG_CIC];
      hbl_stb <= fire[STG_HBL];
      hbh_stb <= fire[STG_HBH];
    end
  end

  // R1: refused factor raises the flag
  assert_err_on_bad_R1: assert property (@(posedge clk) disable iff (rst)
    (load && !d_legal) |=> cfg_err);

  // R2: refused factor keeps the running settings
  assert_hold_on_bad_R2: assert property (@(posedge clk) disable iff (rst)
    (load && !d_legal) |=> $stable({cic_rate, cic_bypass, hbl_en, hbh_en}));

  // R6: bypassed CIC reports unit ratio
  assert_byp_unit_R6: assert property (@(posedge clk) disable iff (rst)
    cic_bypass |-> (cic_rate == RATE_W'(1)));

  // R8: CIC strobe only follows an input sample
  assert_cic_src_R8: assert property (@(posedge clk) disable iff (rst)
    cic_stb |-> $past(in_valid));

  // R9: a later stage only fires together with the one before it
  assert_hbl_order_R9: assert property (@(posedge clk) disable iff (rst)
    hbl_stb |-> cic_stb);
  assert_hbh_order_R9: assert property (@(posedge clk) disable iff (rst)
    hbh_stb |-> hbl_stb);

  // R10: accepted load is followed by a quiet cycle
  assert_quiet_after_load_R10: assert property (@(posedge clk) disable iff (rst)
    apply |=> !cic_stb);

endmodule

// File: tb/sim_decim_chain_ctrl.sv
module sim_decim_chain_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [9:0] factor_in = 10'd1;
  logic       load = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] cic_rate;
  logic       cic_bypass, hbl_en, hbh_en;
  logic       cic_stb, hbl_stb, hbh_stb, cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  decim_chain_ctrl u0 (
    .clk(clk), .rst(rst), .factor_in(factor_in), .load(load),
    .in_valid(in_valid), .cic_rate(cic_rate), .cic_bypass(cic_bypass),
    .hbl_en(hbl_en), .hbh_en(hbh_en), .cic_stb(cic_stb),
    .hbl_stb(hbl_stb), .hbh_stb(hbh_stb), .cfg_err(cfg_err)
  );

  function automatic bit ok_factor(int f);
    if (f >= 1 && f <= 128) return 1;
    if (f > 128 && f <= 256 && (f % 2) == 0) return 1;
    if (f > 256 && f <= 512 && (f % 4) == 0) return 1;
    return 0;
  endfunction

  // Behavioural reference
  int m_rate, c0, c1, c2, r1, r2;
  bit m_hbl, m_hbh, m_err, e_cic, e_hbl, e_hbh, m_app;

  always @(posedge clk) begin
    if (rst) begin
      m_rate = 1; m_hbl = 0; m_hbh = 0; m_err = 0;
      c0 = 0; c1 = 0; c2 = 0;
      e_cic = 0; e_hbl = 0; e_hbh = 0;
    end else begin
      m_app = load && ok_factor(int'(factor_in));
      r1 = m_hbl ? 2 : 1;
      r2 = m_hbh ? 2 : 1;
      e_cic = 0; e_hbl = 0; e_hbh = 0;
      if (in_valid && !m_app) begin
        c0++;
        if (c0 == m_rate) begin c0 = 0; e_cic = 1; end
      end
      if (e_cic) begin
        c1++;
        if (c1 == r1) begin c1 = 0; e_hbl = 1; end
      end
      if (e_hbl) begin
        c2++;
        if (c2 == r2) begin c2 = 0; e_hbh = 1; end
      end
      if (load) begin
        if (m_app) begin
          m_hbl = (factor_in % 4) == 0;
          m_hbh = (factor_in % 2) == 0;
          m_rate = int'(factor_in) / ((m_hbl ? 2 : 1) * (m_hbh ? 2 : 1));
          c0 = 0; c1 = 0; c2 = 0;
          m_err = 0;
        end else begin
          m_err = 1;
        end
      end
    end
  end

  task automatic check(bit good, string tag, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({hbl_en, hbh_en} == {m_hbl, m_hbh}, "R3/R4/R5 halfband enables",
            int'({hbl_en, hbh_en}), int'({m_hbl, m_hbh}));
      check(int'(cic_rate) == m_rate, "R6 cic_rate (R2 hold)", int'(cic_rate), m_rate);
      check(cic_bypass == (m_rate == 1), "R6 cic_bypass", int'(cic_bypass), int'(m_rate == 1));
      check(cfg_err == m_err, "R1/R2 cfg_err", int'(cfg_err), int'(m_err));
      check(cic_stb == e_cic, "R8/R10 cic_stb", int'(cic_stb), int'(e_cic));
      check(hbl_stb == e_hbl, "R9 hbl_stb", int'(hbl_stb), int'(e_hbl));
      check(hbh_stb == e_hbh, "R9 hbh_stb", int'(hbh_stb), int'(e_hbh));
    end
  end

  task automatic run(int n, int pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      load = 1'b0;
      in_valid = ($urandom_range(99) < pct);
    end
  endtask

  task automatic put(int f);
    @(negedge clk);
    factor_in = 10'(f);
    load = 1'b1;
    in_valid = 1'b1;          // R10: this sample must be discarded
    @(negedge clk);
    load = 1'b0;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    checks++;
    if (!(cic_rate == 8'd1 && cic_bypass && !hbl_en && !hbh_en && !cfg_err &&
          !cic_stb && !hbl_stb && !hbh_stb)) begin
      errors++;
      $display("FAIL R7 reset state actual=%0h expected=%0h",
               {cic_rate, cic_bypass, hbl_en, hbh_en, cfg_err, cic_stb, hbl_stb, hbh_stb},
               {8'd1, 7'b1000000});
    end
    run(40, 100);
    foreach (seq[k]) begin
      put(seq[k]);
      run((seq[k] * 6 > 200) ? seq[k] * 6 : 200, (k % 2 == 0) ? 70 : 100);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Legal factors interleaved with refused ones (0, 129, 258, 513, 1023, 514)
  int seq[] = '{4, 6, 129, 7, 1, 0, 2, 3, 128, 258, 130, 256, 513, 260,
                1023, 12, 514, 512, 5};

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule